// File: doc/BRIEF.md
# Programmable duty-cycle clock prescaler

The block divides the system clock into a slower clock for an analog converter. The high phase and the low phase of that clock are set separately: a 5-bit setting gives the high length and a 3-bit setting gives the low length, each in system clocks minus one. One shared 5-bit down counter times both phases.

At the start of each high phase the counter is loaded with the high setting. A zero detect on the counter ends the high phase. The counter keeps counting down through the low phase and wraps from 0 to 31. The low phase ends when the counter's low three bits equal the bitwise inverse of the low setting. Both settings are taken at the high-phase load, so a change part way through a period waits for the next load. A legacy prescaler-add input is accepted and ignored. A strobe marks each rising edge of the derived clock.

The block has no data stream, so there is no valid/ready handshake. All pins are plain control and status pins. The settings are plain levels and have no back-pressure. The derived clock and the strobe are registered outputs that change only on a rising edge of `clk`.

Top module: `qclk_prescaler`

## Requirements
- R1: After each high-phase load, `clk_out` stays 1 for exactly `hi_len`+1 system clocks. This holds for every value from 0 to 31.
- R2: After each high phase, `clk_out` stays 0 for exactly `lo_len`+1 system clocks. This holds for every value from 0 to 7.
- R3: The output period is (`hi_len`+1)+(`lo_len`+1) system clocks, and the phases follow each other without a gap. With `hi_len`=11 and `lo_len`=7 the output is 12 cycles high and 8 cycles low, a 20-cycle period.
- R4: Both settings are sampled only at the high-phase load. A change made during a period does not shorten or lengthen that period, and it shapes the next period.
- R5: The level of `legacy_add` has no effect on `clk_out` or `rise_stb`.
- R6: While `rst` is high at a clock edge, `clk_out` and `rise_stb` are 0. On the first clock edge after `rst` goes low, a fresh high phase starts: `clk_out`=1 and `rise_stb`=1.
- R7: `rise_stb` is 1 for exactly the first system-clock cycle of each high phase, which is the cycle in which `clk_out` rises. It is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hi_len | input | 5 | High-phase length minus one, in system clocks |
| lo_len | input | 3 | Low-phase length minus one, in system clocks |
| legacy_add | input | 1 | Legacy prescaler-add control, ignored |
| clk_out | output | 1 | Derived converter clock |
| rise_stb | output | 1 | One-cycle strobe in the cycle `clk_out` rises |

## Verification
The bench drives the extreme settings. Zero for both settings gives a two-cycle period, and a design that was off by one in the zero detect or the inverse match would stretch or merge phases. A maximum high setting paired with minimum and maximum low settings tests the counter's wrap from 0 to 31: a design that compared the wrong bits, or compared without inverting, would end the low phase at the wrong count. Inside every period the bench writes scrambled settings and flips the legacy bit, so a design that read the settings live, or that used the legacy bit, would truncate or stretch the running phase. A reset in the middle of a run checks that the next period starts cleanly with a strobe and not at a stale count.

// File: rtl/qpre_pkg.sv
package qpre_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/qpre_down_counter.sv
module qpre_down_counter #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         zero
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  // Decrements every clock and wraps naturally from 0 to all ones.
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else           cnt <= cnt - ONE;
  end

  assign zero = (cnt == '0);

  // R1
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt == $past(load_val));
endmodule

// File: rtl/qpre_setting_reg.sv
module qpre_setting_reg #(
  parameter int LO_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [LO_W-1:0] lo_in,
  output logic [LO_W-1:0] lo_q
);
  always_ff @(posedge clk) begin
    if (rst)       lo_q <= '0;
    else if (load) lo_q <= lo_in;
  end

  // R4
  lo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(lo_q));
endmodule

// File: rtl/qpre_phase_ctrl.sv
module qpre_phase_ctrl
  import qpre_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   zero,
  input  logic   lo_match,
  output logic   load,
  output phase_e phase,
  output logic   rise
);
  logic primed;

  // A load happens in the last low cycle, or in the first cycle after reset.
  assign load = (phase == PH_LOW) && (primed || lo_match);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_LOW;
      primed <= 1'b1;
      rise   <= 1'b0;
    end else begin
      primed <= 1'b0;
      rise   <= load;
      if (load)                            phase <= PH_HIGH;
      else if (phase == PH_HIGH && zero)   phase <= PH_LOW;
    end
  end

  // R1
  high_end_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HIGH && zero) |=> phase == PH_LOW);

  // R2
  low_end_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LOW && lo_match && !primed) |=> (phase == PH_HIGH && rise));

  // R7
  rise_edge_chk: assert property (@(posedge clk) disable iff (rst)
    rise |-> (phase == PH_HIGH && $past(phase) == PH_LOW));
endmodule

// File: rtl/qclk_prescaler.sv
module qclk_prescaler
  import qpre_pkg::*;
#(
  parameter int HI_W = 5,
  parameter int LO_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [HI_W-1:0] hi_len,
  input  logic [LO_W-1:0] lo_len,
  input  logic            legacy_add,
  output logic            clk_out,
  output logic            rise_stb
);
  logic [HI_W-1:0] cnt;
  logic [LO_W-1:0] lo_q;
  logic            zero;
  logic            load;
  logic            lo_match;
  phase_e          phase;
  logic            unused_legacy;

  // Kept only for pin compatibility.
  assign unused_legacy = legacy_add;

  qpre_down_counter #(.W(HI_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .load_val(hi_len),
    .cnt(cnt), .zero(zero)
  );

  qpre_setting_reg #(.LO_W(LO_W)) u_lo (
    .clk(clk), .rst(rst), .load(load), .lo_in(lo_len), .lo_q(lo_q)
  );

  // The low phase ends on a ones'-complement match of the low bits.
  assign lo_match = (cnt[LO_W-1:0] == ~lo_q);

  qpre_phase_ctrl u_ctrl (
    .clk(clk), .rst(rst), .zero(zero), .lo_match(lo_match),
    .load(load), .phase(phase), .rise(rise_stb)
  );

  assign clk_out = (phase == PH_HIGH);

  // R6
  reset_start_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |=> (clk_out && rise_stb));

  // R7
  strobe_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_out) |-> rise_stb);
endmodule

// File: tb/qclk_prescaler_bench.sv
module qclk_prescaler_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] hi_len = '0;
  logic [2:0] lo_len = '0;
  logic       legacy_add = 1'b0;
  logic       clk_out;
  logic       rise_stb;

  typedef struct {
    logic  o;
    logic  r;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 0;

  always #5 clk = ~clk;

  qclk_prescaler u_qclk_prescaler (
    .clk(clk), .rst(rst), .hi_len(hi_len), .lo_len(lo_len),
    .legacy_add(legacy_add), .clk_out(clk_out), .rise_stb(rise_stb)
  );

  // Monitor: samples 2 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_vec++;
        if (clk_out !== e.o) begin
          n_bad++;
          $display("FAIL %s clk_out got %b exp %b", e.tag, clk_out, e.o);
        end
        n_vec++;
        if (rise_stb !== e.r) begin
          n_bad++;
          $display("FAIL R7 (%s) rise_stb got %b exp %b", e.tag, rise_stb, e.r);
        end
      end
    end
  end

  // Driver: called at a falling edge just before a high-phase load.
  task automatic period(input int h, input int l, input bit leg, input string tag);
    int n;
    hi_len     = h[4:0];
    lo_len     = l[2:0];
    legacy_add = leg;
    for (int k = 0; k <= h; k++) exp_q.push_back('{1'b1, (k == 0), tag});
    for (int k = 0; k <= l; k++) exp_q.push_back('{1'b0, 1'b0, tag});
    n = h + l + 2;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) begin
        // R4, R5: scrambled settings and legacy bit in mid-period
        hi_len     = ~h[4:0];
        lo_len     = ~l[2:0];
        legacy_add = ~leg;
      end
    end
  endtask

  task automatic check_idle(input string tag);
    n_vec++;
    if (clk_out !== 1'b0 || rise_stb !== 1'b0) begin
      n_bad++;
      $display("FAIL %s reset outputs got %b%b exp 00", tag, clk_out, rise_stb);
    end
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R6");
    rst = 1'b0;
    period(11, 7, 1'b0, "R3");
    period(0, 0, 1'b0, "R1");
    period(0, 0, 1'b1, "R2");
    period(31, 7, 1'b0, "R1");
    period(31, 0, 1'b0, "R2");
    period(0, 7, 1'b0, "R2");
    period(5, 2, 1'b1, "R5");
    period(5, 2, 1'b0, "R5");
    period(6, 1, 1'b0, "R4");
    period(2, 6, 1'b1, "R4");
    // R6: reset in the middle of a run
    rst = 1'b1;
    @(negedge clk);
    check_idle("R6");
    @(negedge clk);
    check_idle("R6");
    rst = 1'b0;
    period(11, 7, 1'b0, "R6");
    period(3, 3, 1'b0, "R3");
    rst = 1'b1;
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule